// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer Base

This block is a 16-bit up-counting time base. A divide counter slows the input clock by a programmable ratio, and each resulting tick advances the main counter. When the counter reaches the programmed limit, it wraps to zero. Software sets up the block through a plain register write port. It can read back the counter and the two staged settings through a combinational read port.

The divide ratio and the wrap limit are double-buffered. Writes land in staged copies, and the working copies change only on an update event. Three things cause an update event: a counter wrap, a software update strobe, and an external restart trigger. Every update event does four things:

- clears the counter;
- restarts the divide phase;
- copies both staged settings into the working copies;
- raises a one-cycle `update_o` pulse on the following cycle.

While the working limit is zero, the counter is frozen. The block has no streaming data path, so every pin is a plain control or status signal.

Top module: `tick_timebase`

## Requirements
- R1: After reset, `count_o`, both staged settings and both working settings are 0, and `update_o` is 0.
- R2: A write with `wr_addr` 0 targets the counter, 1 the staged divide value, and 2 the staged limit. `rd_data` returns the counter for `rd_addr` 0, the staged divide value for 1, the staged limit for 2, and 0 for 3.
- R3: With working divide value P and no other activity, the counter advances once every P+1 clock cycles.
- R4: A divide-value write changes only the staged copy. The counting rate keeps the old ratio until the next update event.
- R5: A limit write changes only the staged copy. The working limit keeps its old value until the next update event.
- R6: While the working limit is 0, the counter holds its value on ticks, and no wrap occurs.
- R7: On a tick where the counter is greater than or equal to a nonzero working limit, the counter becomes 0. `update_o` is high for the next cycle only.
- R8: A cycle with `sw_update_i` high is an update event. After the next edge, the counter is 0, the divide phase is 0, the working settings hold the staged values, and `update_o` is 1.
- R9: A cycle with `ext_trig_i` high has exactly the same effect as R8.
- R10: A counter write sets `count_o` to the written value at the next edge and does not raise `update_o`.
- R11: When a staged-setting write and an update event fall in the same cycle, the written value is the one copied into the working setting.
- R12: When a counter write and an update event fall in the same cycle, the update event wins and the counter becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write target: 0 counter, 1 divide, 2 limit |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 2 | Read select |
| rd_data_o | output | 16 | Combinational read data |
| sw_update_i | input | 1 | Software update strobe |
| ext_trig_i | input | 1 | External restart trigger |
| count_o | output | 16 | Current counter value |
| update_o | output | 1 | One-cycle pulse after each update event |

## Verification
The assertions assume that every input is a clean synchronous level sampled at the rising edge. They also assume that a strobe held high for several cycles is meant as repeated update events, not a single one. Under these assumptions, the divide phase can never exceed the working ratio, and every `update_o` cycle shows a zero counter.

The bench drives inputs only at falling edges. It mixes rare random strobes, writes and small settings with directed sequences that put writes and events in the same cycle. It compares every cycle against a model built from the requirements.

// File: rtl/tick_timebase_pkg.sv
package tick_timebase_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_COUNT  = 2'd0,
    SEL_DIV    = 2'd1,
    SEL_LIMIT  = 2'd2,
    SEL_UNUSED = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tb_setting_regs.sv
module tb_setting_regs
  import tick_timebase_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              load_i,
  output logic [W-1:0]      div_stage_o,
  output logic [W-1:0]      lim_stage_o,
  output logic [W-1:0]      div_work_o,
  output logic [W-1:0]      lim_work_o
);
  logic [W-1:0] div_next, lim_next;

  // A write in the same cycle as a load is forwarded into the working copy
  always_comb begin
    div_next = div_stage_o;
    lim_next = lim_stage_o;
    if (wr_en_i && reg_sel_e'(wr_addr_i) == SEL_DIV)   div_next = wr_data_i;
    if (wr_en_i && reg_sel_e'(wr_addr_i) == SEL_LIMIT) lim_next = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_stage_o <= '0;
      lim_stage_o <= '0;
      div_work_o  <= '0;
      lim_work_o  <= '0;
    end else begin
      div_stage_o <= div_next;
      lim_stage_o <= lim_next;
      if (load_i) begin
        div_work_o <= div_next;
        lim_work_o <= lim_next;
      end
    end
  end

  AST_WORK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(div_work_o) && $stable(lim_work_o))); // R4

  AST_LOAD_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && wr_en_i && reg_sel_e'(wr_addr_i) == SEL_LIMIT)
      |=> (lim_work_o == $past(wr_data_i))); // R11
endmodule

// File: rtl/tb_divider.sv
module tb_divider
  import tick_timebase_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic [W-1:0] ratio_i,
  output logic         tick_o
);
  logic [W-1:0] phase;

  assign tick_o = (phase == ratio_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase <= '0;
    else if (clear_i || tick_o) phase <= '0;
    else                        phase <= phase + 1'b1;
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= ratio_i); // R3

  AST_PHASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (phase == '0)); // R8
endmodule

// File: rtl/tb_main_counter.sv
module tb_main_counter
  import tick_timebase_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  input  logic         restart_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] count_o,
  output logic         event_o,
  output logic         update_o
);
  logic limit_zero, wrap;

  assign limit_zero = (limit_i == '0);
  assign wrap       = tick_i && !limit_zero && (count_o >= limit_i);
  assign event_o    = wrap || restart_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o  <= '0;
      update_o <= 1'b0;
    end else begin
      update_o <= event_o;
      if (event_o)                  count_o <= '0;
      else if (wr_i)                count_o <= wr_data_i;
      else if (tick_i && !limit_zero) count_o <= count_o + 1'b1;
    end
  end

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_zero && !restart_i && !wr_i) |=> $stable(count_o)); // R6

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !event_o) |=> (count_o == $past(wr_data_i) && !update_o)); // R10
endmodule

// File: rtl/tick_timebase.sv
module tick_timebase
  import tick_timebase_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [W-1:0]      rd_data_o,
  input  logic              sw_update_i,
  input  logic              ext_trig_i,
  output logic [W-1:0]      count_o,
  output logic              update_o
);
  logic [W-1:0] div_stage, lim_stage, div_work, lim_work;
  logic         tick, upd_event, restart, cnt_wr;

  assign restart = sw_update_i || ext_trig_i;
  assign cnt_wr  = wr_en_i && reg_sel_e'(wr_addr_i) == SEL_COUNT;

  tb_setting_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .load_i(upd_event),
    .div_stage_o(div_stage), .lim_stage_o(lim_stage),
    .div_work_o(div_work), .lim_work_o(lim_work)
  );

  tb_divider #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .clear_i(upd_event),
    .ratio_i(div_work), .tick_o(tick)
  );

  tb_main_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .limit_i(lim_work),
    .restart_i(restart), .wr_i(cnt_wr), .wr_data_i(wr_data_i),
    .count_o(count_o), .event_o(upd_event), .update_o(update_o)
  );

  always_comb begin
    unique case (reg_sel_e'(rd_addr_i))
      SEL_COUNT: rd_data_o = count_o;
      SEL_DIV:   rd_data_o = div_stage;
      SEL_LIMIT: rd_data_o = lim_stage;
      default:   rd_data_o = '0;
    endcase
  end

  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> update_o); // R8

  AST_PULSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |-> (count_o == '0)); // R7

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && cnt_wr) |=> (count_o == '0)); // R12
endmodule

// File: tb/tb_tick_timebase.sv
module tb_tick_timebase;
  localparam int CLK_P = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [1:0]   wr_addr_i = '0;
  logic [W-1:0] wr_data_i = '0;
  logic [1:0]   rd_addr_i = '0;
  logic [W-1:0] rd_data_o;
  logic         sw_update_i = 1'b0;
  logic         ext_trig_i = 1'b0;
  logic [W-1:0] count_o;
  logic         update_o;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_cnt, m_ph, m_div_s, m_lim_s, m_div_w, m_lim_w;
  logic         m_upd;

  always #(CLK_P/2) clk = ~clk;

  tick_timebase dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_ph = 0; m_div_s = 0; m_lim_s = 0;
    m_div_w = 0; m_lim_w = 0; m_upd = 0;
  endtask

  // Next-state model derived from R3..R12
  task automatic model_step();
    logic tk, wr, ev;
    logic [W-1:0] nd, nl;
    tk = (m_ph == m_div_w);
    wr = (m_lim_w != 0) && tk && (m_cnt >= m_lim_w);
    ev = wr || sw_update_i || ext_trig_i;
    nd = (wr_en_i && wr_addr_i == 2'd1) ? wr_data_i : m_div_s;
    nl = (wr_en_i && wr_addr_i == 2'd2) ? wr_data_i : m_lim_s;
    if (ev)                                m_cnt = 0;
    else if (wr_en_i && wr_addr_i == 2'd0) m_cnt = wr_data_i;
    else if (tk && m_lim_w != 0)           m_cnt = m_cnt + 1'b1;
    m_ph = (ev || tk) ? '0 : m_ph + 1'b1;
    if (ev) begin m_div_w = nd; m_lim_w = nl; end
    m_div_s = nd; m_lim_s = nl; m_upd = ev;
  endtask

  task automatic cyc(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk({tag, " count"}, int'(count_o), int'(m_cnt));
    chk({tag, " update"}, int'(update_o), int'(m_upd));
    wr_en_i = 0; sw_update_i = 0; ext_trig_i = 0;
  endtask

  task automatic wreg(logic [1:0] a, logic [W-1:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
  endtask

  task automatic rd(string tag, logic [1:0] a, int exp);
    rd_addr_i = a;
    #1;
    chk(tag, int'(rd_data_o), exp);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 count", int'(count_o), 0);
    chk("R1 update", int'(update_o), 0);
    rd("R1 div stage", 2'd1, 0);
    rd("R1 lim stage", 2'd2, 0);
    // R2 write/read map
    wreg(2'd2, 16'd3); cyc("R5 write lim");
    wreg(2'd1, 16'd1); cyc("R4 write div");
    rd("R2 read lim", 2'd2, 3);
    rd("R2 read div", 2'd1, 1);
    rd("R2 read unused", 2'd3, 0);
    // R6: working limit still 0, counter frozen
    for (int i = 0; i < 6; i++) cyc("R6 frozen");
    chk("R6 frozen value", int'(count_o), 0);
    // R8 software update loads settings
    sw_update_i = 1; cyc("R8 sw update");
    chk("R8 pulse", int'(update_o), 1);
    // R3 one step per two cycles, R7 wrap at 3
    for (int i = 0; i < 6; i++) cyc("R3 rate");
    chk("R3 value after 6", int'(count_o), 3);
    cyc("R7 pre"); cyc("R7 wrap");
    chk("R7 wrapped", int'(count_o), 0);
    chk("R7 pulse", int'(update_o), 1);
    cyc("R7 single");
    chk("R7 pulse once", int'(update_o), 0);
    // R4 staged divide not yet active
    wreg(2'd1, 16'd0); cyc("R4 stage");
    for (int i = 0; i < 4; i++) cyc("R4 old ratio");
    // R10 counter write
    wreg(2'd0, 16'd2); cyc("R10 write");
    chk("R10 value", int'(count_o), 2);
    chk("R10 no pulse", int'(update_o), 0);
    // R9 external trigger, R12 event beats counter write
    ext_trig_i = 1; wreg(2'd0, 16'd9); cyc("R12 trig+write");
    chk("R12 cleared", int'(count_o), 0);
    chk("R9 pulse", int'(update_o), 1);
    for (int i = 0; i < 5; i++) cyc("R9 new ratio");
    // R11 write and update in same cycle
    sw_update_i = 1; wreg(2'd2, 16'd5); cyc("R11 fwd");
    for (int i = 0; i < 8; i++) cyc("R11 limit 5");
    chk("R11 limit 5 reached", int'(count_o), 2);
    // R5: staged limit 0 does not freeze until update
    wreg(2'd2, 16'd0); cyc("R5 stage zero");
    for (int i = 0; i < 3; i++) cyc("R5 still running");
    sw_update_i = 1; cyc("R6 load zero");
    for (int i = 0; i < 4; i++) cyc("R6 frozen again");
    // Random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 4) begin
        wreg(2'($urandom_range(0, 2)), 16'($urandom_range(0, 9)));
        if (wr_addr_i == 2'd1) wr_data_i = 16'($urandom_range(0, 3));
      end
      sw_update_i = ($urandom_range(0, 99) < 2);
      ext_trig_i  = ($urandom_range(0, 99) < 2);
      cyc("R3 random");
      if ((i % 100) == 0) begin
        rd("R2 random lim", 2'd2, int'(m_lim_s));
        rd("R2 random div", 2'd1, int'(m_div_s));
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule